// File: doc/BRIEF.md
# NAND Command and Address Latch Sequencer

This block turns simple host requests into the control-line sequences an 8-bit raw NAND flash expects. One request is handled at a time. The block can:

- send one command byte;
- send a main-area read command whose byte is derived from the offset;
- send an address of one, two or three bytes taken from a byte offset;
- wait for the flash ready line;
- select a chip or a floor;
- send a status command and read back the pass/fail bit.

Every step is framed by fixed settle gaps. A gap is measured in delay units of `DELAY_CLKS` system clocks each (written D below).

The chip-enable, command-latch, address-latch and write-protect lines are held in a register. They keep their last value between requests. The host handshake has three signals:

- `req_start`, which is taken only while the block is idle;
- `req_busy`;
- a one-clock `req_done`.

Result flags for a ready timeout, a program or erase failure, and a rejected request are cleared when a request is accepted. They then hold until the next accepted request. All flash-side levels are active high.

Top module: `nand_seq_top`

## Requirements
- R1: During and right after reset, every flash output, the selects, `req_busy`, `req_done` and all result flags are 0.
- R2: A request is accepted on a clock edge where `req_start` is 1 and `req_busy` is 0. `req_busy` is 1 from the next cycle until the done cycle. `req_done` is 1 for one cycle with `req_busy` 0. A `req_start` seen while busy has no effect on any output, selects included.
- R3: Command request (`req_op` 0) timing:
  - for 4D cycles, CE=1, CLE=1 and WP=`req_latch_wp`;
  - for one cycle, `nand_we`=1 and `nand_dq_oe`=1, with the byte on `nand_dq_o`;
  - for 4D cycles, CLE=0 with CE kept at 1;
  - then done.
- R4: Address request (`req_op` 2) uses the same framing with ALE in place of CLE and one write cycle per byte. When ALE drops, WP becomes `req_latch_wp | req_release_wp`.
- R5: With `req_alen`=3, the address bytes are offset[7:0], then offset[16:9], then offset[24:17] (zero above the offset width).
- R6: With `req_alen`=2, the bytes are offset[16:9] then offset[24:17]. With `req_alen`=1, the only byte is offset[7:0]. Offset bit 8 is never sent as address.
- R7: Read command (`req_op` 1) sends the byte {7'b0, offset[8]} with R3 framing.
- R8: Ready wait (`req_op` 3) takes these steps:
  - 4D cycles of delay;
  - one `nand_rdy` sample per clock until a sample is 1;
  - 2D cycles of delay;
  - then done.
- R9: If RDY_LIMIT (65535) samples in a row are 0, `res_timeout` is set and the 2D tail still follows. A 1 on the last allowed sample is not a timeout. `res_timeout` holds until the next accept.
- R10: Chip select (`req_op` 5) loads `chip_sel` from `req_sel` in the cycle after accept, then spends 4D cycles, then runs an R8 wait. Floor select (`req_op` 6) loads `floor_sel` and runs an R8 wait directly.
- R11: Status request (`req_op` 4) sends byte 0x70 with R3 framing. It then spends 2D cycles and one cycle with `nand_re`=1, and captures `nand_dq_i[0]` into `res_fail`, which is visible in the done cycle.
- R12: An address request with `req_alen` not in 1..3, or `req_op` 7, is rejected. `req_done` and `res_reject` are 1 in the next cycle with `req_busy` 0, and CE, CLE, ALE and WP keep their values.
- R13: CLE and ALE are never 1 together. `nand_dq_oe` is 1 only in byte write cycles, and `nand_dq_o` is 0 when not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code (see requirements) |
| req_cmd | input | 8 | Command byte for `req_op` 0 |
| req_offset | input | ADDR_W | Byte offset for address and read-command requests |
| req_alen | input | 3 | Address byte count |
| req_latch_wp | input | 1 | WP level while a latch line is raised |
| req_release_wp | input | 1 | Extra WP level ORed in when ALE drops |
| req_sel | input | SEL_W | Chip or floor number |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-cycle completion pulse |
| res_timeout | output | 1 | Ready wait ran out of samples |
| res_fail | output | 1 | Status bit 0 from the last status request |
| res_reject | output | 1 | Last request was rejected |
| nand_ce | output | 1 | Chip enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp | output | 1 | Write protect |
| nand_we | output | 1 | Byte write strobe |
| nand_re | output | 1 | Byte read strobe |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy | input | 1 | Flash ready (1) / busy (0) |
| floor_sel | output | SEL_W | Registered floor number |
| chip_sel | output | SEL_W | Registered chip number |

## Verification
The sample counter reaching its limit can fall in the same cycle as the ready line rising. The bench provokes this by raising `nand_rdy` exactly on the 65535th sample and expects no timeout, then holds it low for a second wait and expects `res_timeout`. A done pulse and the next accept can also coincide: requests are launched in the done cycle of the previous one. A stray `req_start` injected mid-request must leave the trace, and `floor_sel`, unchanged. Every cycle is compared against a queue of expected output vectors built from the requirements.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    OP_CMD      = 3'd0,
    OP_RDCMD    = 3'd1,
    OP_ADDR     = 3'd2,
    OP_WAIT     = 3'd3,
    OP_STATUS   = 3'd4,
    OP_SELCHIP  = 3'd5,
    OP_SELFLOOR = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  localparam logic [7:0] STATUS_BYTE = 8'h70;
  localparam logic [2:0] LATCH_UNITS = 3'd4;
  localparam logic [2:0] PRE_UNITS   = 3'd4;
  localparam logic [2:0] POST_UNITS  = 3'd2;
  localparam logic [2:0] GAP_UNITS   = 3'd2;

  // clocks spent for a number of delay units
  function automatic int delay_span(input logic [2:0] units, input int ticks);
    return int'(units) * ticks;
  endfunction

  // address byte count accepted by the sequencer
  function automatic logic alen_ok(input logic [2:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd3);
  endfunction

  // main-area read command: half-page choice comes from offset bit 8
  function automatic logic [7:0] read_cmd(input logic [31:0] off);
    return {7'b0, off[8]};
  endfunction

  // byte idx of an address sequence of len bytes; bit 8 is skipped
  function automatic logic [7:0] addr_byte(input logic [31:0] off,
                                           input logic [1:0]  len,
                                           input logic [1:0]  idx);
    logic [1:0] lane;
    logic [7:0] b;
    lane = (len == 2'd2) ? idx + 2'd1 : idx;
    case (lane)
      2'd0:    b = off[7:0];
      2'd1:    b = off[16:9];
      default: b = off[24:17];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nand_delay_timer.sv
module nand_delay_timer
  import nand_seq_pkg::*;
#(
  parameter int TICKS     = 1,
  parameter int MAX_UNITS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] units,
  output logic       expire
);
  localparam int CW = $clog2(MAX_UNITS * TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= CW'(delay_span(units, TICKS) - 1);
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nand_ready_poll.sv
module nand_ready_poll #(
  parameter int LIMIT = 65535,
  localparam int PW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample_en,
  input  logic          rdy,
  output logic          hit,
  output logic          exhaust,
  output logic [PW-1:0] count
);
  assign hit     = sample_en && rdy;
  assign exhaust = sample_en && !rdy && (count == PW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                            count <= '0;
    else if (clear)                        count <= '0;
    else if (sample_en && !rdy && !exhaust) count <= count + 1'b1;
  end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int DELAY_CLKS = 1,
  parameter int ADDR_W     = 24,
  parameter int SEL_W      = 2,
  parameter int RDY_LIMIT  = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [2:0]        req_op,
  input  logic [7:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [2:0]        req_alen,
  input  logic              req_latch_wp,
  input  logic              req_release_wp,
  input  logic [SEL_W-1:0]  req_sel,
  output logic              req_busy,
  output logic              req_done,
  output logic              res_timeout,
  output logic              res_fail,
  output logic              res_reject,
  output logic              nand_ce,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_wp,
  output logic              nand_we,
  output logic              nand_re,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rdy,
  output logic [SEL_W-1:0]  floor_sel,
  output logic [SEL_W-1:0]  chip_sel
);
  localparam int PW = $clog2(RDY_LIMIT + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_LATCH, ST_BYTES, ST_RELEASE, ST_GAP,
    ST_READ, ST_SETTLE, ST_PRE, ST_SAMPLE, ST_POST
  } st_e;

  st_e               st_q, st_d;
  op_e               op_q, op_in;
  logic [1:0]        alen_q, idx_q;
  logic              wa_q, wb_q;
  logic [7:0]        cmd_q, byte_now;
  logic [ADDR_W-1:0] off_q;

  // named events for the checker
  logic              accept_w, reject_w, last_byte_w;
  logic              tmr_load, tmr_expire;
  logic [2:0]        tmr_units;
  logic              poll_clear, poll_en, poll_hit, poll_exhaust;
  logic [PW-1:0]     poll_count;

  assign op_in       = op_e'(req_op);
  assign accept_w    = req_start && (st_q == ST_IDLE);
  assign reject_w    = accept_w &&
                       ((op_in == OP_RSVD) || ((op_in == OP_ADDR) && !alen_ok(req_alen)));
  assign last_byte_w = (op_q != OP_ADDR) || (idx_q == alen_q - 2'd1);
  assign byte_now    = (op_q == OP_ADDR) ? addr_byte(32'(off_q), alen_q, idx_q) : cmd_q;

  assign poll_en    = (st_q == ST_SAMPLE);
  assign poll_clear = (st_q == ST_PRE) && tmr_expire;

  assign req_busy   = (st_q != ST_IDLE);
  assign nand_we    = (st_q == ST_BYTES);
  assign nand_dq_oe = (st_q == ST_BYTES);
  assign nand_dq_o  = (st_q == ST_BYTES) ? byte_now : 8'h00;
  assign nand_re    = (st_q == ST_READ);

  nand_delay_timer #(.TICKS(DELAY_CLKS), .MAX_UNITS(4)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .units(tmr_units), .expire(tmr_expire)
  );

  nand_ready_poll #(.LIMIT(RDY_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear), .sample_en(poll_en),
    .rdy(nand_rdy), .hit(poll_hit), .exhaust(poll_exhaust), .count(poll_count)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_units = LATCH_UNITS;
    case (st_q)
      ST_IDLE: if (accept_w && !reject_w) begin
        tmr_load = 1'b1;
        case (op_in)
          OP_WAIT, OP_SELFLOOR: begin st_d = ST_PRE; tmr_units = PRE_UNITS; end
          OP_SELCHIP:           st_d = ST_SETTLE;
          default:              st_d = ST_LATCH;
        endcase
      end
      ST_LATCH:   if (tmr_expire) st_d = ST_BYTES;
      ST_BYTES:   if (last_byte_w) begin tmr_load = 1'b1; st_d = ST_RELEASE; end
      ST_RELEASE: if (tmr_expire) begin
        if (op_q == OP_STATUS) begin
          tmr_load = 1'b1; tmr_units = GAP_UNITS; st_d = ST_GAP;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_GAP:     if (tmr_expire) st_d = ST_READ;
      ST_READ:    st_d = ST_IDLE;
      ST_SETTLE:  if (tmr_expire) begin tmr_load = 1'b1; tmr_units = PRE_UNITS; st_d = ST_PRE; end
      ST_PRE:     if (tmr_expire) st_d = ST_SAMPLE;
      ST_SAMPLE:  if (poll_hit || poll_exhaust) begin
        tmr_load = 1'b1; tmr_units = POST_UNITS; st_d = ST_POST;
      end
      ST_POST:    if (tmr_expire) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_CMD;
      alen_q      <= '0;
      idx_q       <= '0;
      wa_q        <= 1'b0;
      wb_q        <= 1'b0;
      cmd_q       <= '0;
      off_q       <= '0;
      req_done    <= 1'b0;
      res_timeout <= 1'b0;
      res_fail    <= 1'b0;
      res_reject  <= 1'b0;
      nand_ce     <= 1'b0;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_wp     <= 1'b0;
      floor_sel   <= '0;
      chip_sel    <= '0;
    end else begin
      st_q     <= st_d;
      req_done <= (st_q != ST_IDLE) && (st_d == ST_IDLE);

      if (accept_w) begin
        op_q        <= op_in;
        alen_q      <= req_alen[1:0];
        off_q       <= req_offset;
        wa_q        <= req_latch_wp;
        wb_q        <= req_release_wp;
        idx_q       <= '0;
        res_timeout <= 1'b0;
        res_fail    <= 1'b0;
        res_reject  <= reject_w;
        case (op_in)
          OP_RDCMD:  cmd_q <= read_cmd(32'(req_offset));
          OP_STATUS: cmd_q <= STATUS_BYTE;
          default:   cmd_q <= req_cmd;
        endcase
        if (reject_w) begin
          req_done <= 1'b1;
        end else begin
          case (op_in)
            OP_CMD, OP_RDCMD, OP_STATUS: begin
              nand_ce <= 1'b1; nand_cle <= 1'b1; nand_ale <= 1'b0; nand_wp <= req_latch_wp;
            end
            OP_ADDR: begin
              nand_ce <= 1'b1; nand_ale <= 1'b1; nand_cle <= 1'b0; nand_wp <= req_latch_wp;
            end
            OP_SELCHIP:  chip_sel  <= req_sel;
            OP_SELFLOOR: floor_sel <= req_sel;
            default: ;
          endcase
        end
      end

      if (st_q == ST_BYTES) begin
        idx_q <= idx_q + 2'd1;
        if (last_byte_w) begin
          nand_cle <= 1'b0;
          nand_ale <= 1'b0;
          nand_wp  <= wa_q | ((op_q == OP_ADDR) && wb_q);
        end
      end

      if (poll_exhaust)      res_timeout <= 1'b1;
      if (st_q == ST_READ)   res_fail    <= nand_dq_i[0];
    end
  end
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker #(
  parameter int RDY_LIMIT = 65535,
  localparam int PW       = $clog2(RDY_LIMIT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic          req_busy,
  input logic          req_done,
  input logic          res_timeout,
  input logic          res_reject,
  input logic          nand_ce,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_wp,
  input logic          nand_we,
  input logic          nand_re,
  input logic          nand_dq_oe,
  input logic          reject_w,
  input logic          poll_exhaust,
  input logic [PW-1:0] poll_count
);
  // R13: latch lines exclusive
  a_r13_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R13: write strobe only with chip enabled and bus driven
  a_r13_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
    nand_we |-> (nand_ce && nand_dq_oe && !nand_re));

  // R11: read strobe never while driving
  a_r11_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re |-> (nand_ce && !nand_dq_oe));

  // R2: busy only starts after a request
  a_r2_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_busy) |-> $past(req_start));

  // R2: done shown with busy low
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !req_busy);

  // R12: rejected request touches no line
  a_r12_reject_static: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> ($stable({nand_ce, nand_cle, nand_ale, nand_wp}) && res_reject && req_done));

  // R9: sample counter bounded
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count <= PW'(RDY_LIMIT - 1));

  // R9: timeout flag only from an exhausted poll
  a_r9_timeout_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_timeout) |-> $past(poll_exhaust));
endmodule

bind nand_seq_top nand_seq_checker #(.RDY_LIMIT(RDY_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_busy(req_busy),
  .req_done(req_done), .res_timeout(res_timeout), .res_reject(res_reject),
  .nand_ce(nand_ce), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_wp(nand_wp),
  .nand_we(nand_we), .nand_re(nand_re), .nand_dq_oe(nand_dq_oe),
  .reject_w(reject_w), .poll_exhaust(poll_exhaust), .poll_count(poll_count)
);

// File: tb/nand_seq_top_test.sv
module nand_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DCLK       = 1;
  localparam int LIMIT      = 65535;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_cmd = '0;
  logic [23:0] req_offset = '0;
  logic [2:0]  req_alen = 3'd1;
  logic        req_latch_wp = 1'b0, req_release_wp = 1'b0;
  logic [1:0]  req_sel = '0;
  logic        req_busy, req_done, res_timeout, res_fail, res_reject;
  logic        nand_ce, nand_cle, nand_ale, nand_wp, nand_we, nand_re, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rdy = 1'b1;
  logic [1:0]  floor_sel, chip_sel;

  int nchecks = 0, nerr = 0, ncyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_seq_top #(.DELAY_CLKS(DCLK), .ADDR_W(24), .SEL_W(2), .RDY_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op), .req_cmd(req_cmd),
    .req_offset(req_offset), .req_alen(req_alen), .req_latch_wp(req_latch_wp),
    .req_release_wp(req_release_wp), .req_sel(req_sel), .req_busy(req_busy),
    .req_done(req_done), .res_timeout(res_timeout), .res_fail(res_fail),
    .res_reject(res_reject), .nand_ce(nand_ce), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_wp(nand_wp), .nand_we(nand_we), .nand_re(nand_re), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy),
    .floor_sel(floor_sel), .chip_sel(chip_sel)
  );

  // behavioural model state
  logic       m_ce = 0, m_cle = 0, m_ale = 0, m_wp = 0, m_we = 0, m_re = 0, m_oe = 0;
  logic [7:0] m_dq = 0;
  logic       m_busy = 0, m_done = 0, m_to = 0, m_fail = 0, m_rej = 0;
  logic [1:0] m_floor = 0, m_chip = 0;
  logic [23:0] expq[$];

  function automatic logic [23:0] mvec();
    return {m_ce, m_cle, m_ale, m_wp, m_we, m_re, m_oe, m_dq, m_busy, m_done,
            m_floor, m_chip, m_to, m_fail, m_rej};
  endfunction

  function automatic logic [23:0] gvec();
    return {nand_ce, nand_cle, nand_ale, nand_wp, nand_we, nand_re, nand_dq_oe, nand_dq_o,
            req_busy, req_done, floor_sel, chip_sel, res_timeout, res_fail, res_reject};
  endfunction

  task automatic emit(input int n);
    for (int i = 0; i < n; i++) expq.push_back(mvec());
  endtask

  task automatic check(input string tag, input int cyc, input logic [23:0] g, input logic [23:0] e);
    nchecks++;
    if (g !== e) begin
      nerr++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, g, e);
    end
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc == WATCHDOG) begin
      nerr++;
      nchecks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", ncyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  // write-cycle framing shared by command-type and address requests
  task automatic model_frame(input bit is_addr, input bit wa, input bit wb,
                             input int nb, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2);
    logic [7:0] bl[3];
    bl[0] = b0; bl[1] = b1; bl[2] = b2;
    m_ce = 1; m_wp = wa;
    if (is_addr) m_ale = 1; else m_cle = 1;
    emit(4 * DCLK);
    for (int i = 0; i < nb; i++) begin
      m_we = 1; m_oe = 1; m_dq = bl[i];
      emit(1);
    end
    m_we = 0; m_oe = 0; m_dq = 0; m_cle = 0; m_ale = 0;
    m_wp = wa | (is_addr & wb);
    emit(4 * DCLK);
  endtask

  task automatic model_wait(input int rdy_at);
    emit(4 * DCLK);
    for (int k = 1; ; k++) begin
      int cyc;
      cyc = expq.size() + 1;
      if (cyc >= rdy_at) begin emit(1); break; end
      if (k == LIMIT) begin emit(1); m_to = 1; break; end
      emit(1);
    end
    emit(2 * DCLK);
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [7:0] cmd,
                        input logic [23:0] off, input logic [2:0] alen, input bit wa,
                        input bit wb, input logic [1:0] sel, input int rdy_at,
                        input logic [7:0] dqi, input bit poke);
    int L;
    logic [7:0] a0, a9, a17;
    a0 = off & 24'hff; a9 = (off >> 9) & 24'hff; a17 = (off >> 17) & 24'hff;
    expq.delete();
    m_to = 0; m_fail = 0; m_rej = 0; m_busy = 1; m_done = 0;
    if (op == 3'd7 || (op == 3'd2 && (alen < 1 || alen > 3))) begin
      m_busy = 0; m_rej = 1; m_done = 1; emit(1); m_done = 0;
    end else begin
      case (op)
        3'd0: model_frame(0, wa, wb, 1, cmd, 0, 0);
        3'd1: model_frame(0, wa, wb, 1, {7'b0, off[8]}, 0, 0);
        3'd2: begin
          if (alen == 3)      model_frame(1, wa, wb, 3, a0, a9, a17);
          else if (alen == 2) model_frame(1, wa, wb, 2, a9, a17, 0);
          else                model_frame(1, wa, wb, 1, a0, 0, 0);
        end
        3'd4: begin
          model_frame(0, wa, wb, 1, 8'h70, 0, 0);
          emit(2 * DCLK);
          m_re = 1; emit(1); m_re = 0;
          m_fail = dqi[0];
        end
        3'd5: begin m_chip = sel; emit(4 * DCLK); model_wait(rdy_at); end
        3'd6: begin m_floor = sel; model_wait(rdy_at); end
        default: model_wait(rdy_at);
      endcase
      m_busy = 0; m_done = 1; emit(1); m_done = 0;
    end
    L = expq.size();
    req_op = op; req_cmd = cmd; req_offset = off; req_alen = alen;
    req_latch_wp = wa; req_release_wp = wb; req_sel = sel; nand_dq_i = dqi;
    nand_rdy = (rdy_at <= 0);
    req_start = 1;
    @(posedge clk);
    for (int c = 1; c <= L; c++) begin
      @(negedge clk);
      if (c == 1) req_start = 0;
      nand_rdy = (c >= rdy_at);
      check(tag, c, gvec(), expq.pop_front());
      if (poke && c == 3) begin req_start = 1; req_op = 3'd6; req_sel = ~sel; end
      if (poke && c == 4) begin req_start = 0; req_op = op; req_sel = sel; end
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, i, gvec(), mvec());
    end
  endtask

  initial begin
    // R1: reset state
    repeat (2) begin @(negedge clk); check("R1", 0, gvec(), mvec()); end
    rst_n = 1;
    idle("R1", 2);

    // R3 R13: command framing
    run_op("R3 R13", 3'd0, 8'hFF, 0, 3'd1, 1, 0, 0, 0, 8'h00, 0);
    // R2: back-to-back accept in the done cycle plus stray start while busy
    run_op("R2", 3'd0, 8'h90, 0, 3'd1, 0, 1, 2'd1, 0, 8'h00, 1);
    idle("R2", 2);
    // R4 R5: three-byte address, order and WP release
    run_op("R4 R5", 3'd2, 8'h00, 24'hABCDEF, 3'd3, 1, 0, 0, 0, 8'h00, 0);
    // R4 R6: two-byte address with extra release flag
    run_op("R4 R6", 3'd2, 8'h00, 24'h3F5A31, 3'd2, 0, 1, 0, 0, 8'h00, 0);
    // R6: one-byte address
    run_op("R6", 3'd2, 8'h00, 24'h00011C, 3'd1, 0, 0, 0, 0, 8'h00, 0);
    // R12: rejected requests leave lines alone
    run_op("R12", 3'd2, 8'h00, 24'h123456, 3'd0, 1, 1, 0, 0, 8'h00, 0);
    run_op("R12", 3'd2, 8'h00, 24'h123456, 3'd5, 0, 1, 0, 0, 8'h00, 0);
    run_op("R12", 3'd7, 8'h00, 24'h0, 3'd1, 1, 1, 0, 0, 8'h00, 0);
    idle("R12", 3);
    // R7: read command carries offset bit 8
    run_op("R7", 3'd1, 8'h55, 24'h000100, 3'd1, 1, 0, 0, 0, 8'h00, 0);
    run_op("R7", 3'd1, 8'h55, 24'h0002FF, 3'd1, 0, 0, 0, 0, 8'h00, 0);
    // R8: ready immediately and after some busy samples
    run_op("R8", 3'd3, 8'h00, 0, 3'd1, 0, 0, 0, 1, 8'h00, 0);
    run_op("R8", 3'd3, 8'h00, 0, 3'd1, 0, 0, 0, 12, 8'h00, 0);
    // R10: chip and floor select
    run_op("R10", 3'd5, 8'h00, 0, 3'd1, 0, 0, 2'd2, 3, 8'h00, 0);
    run_op("R10", 3'd6, 8'h00, 0, 3'd1, 0, 0, 2'd1, 9, 8'h00, 0);
    // R11: status pass and fail
    run_op("R11", 3'd4, 8'h00, 0, 3'd1, 1, 0, 0, 0, 8'h01, 0);
    run_op("R11", 3'd4, 8'h00, 0, 3'd1, 0, 0, 0, 0, 8'hFE, 0);
    idle("R11", 2);
    // R9: ready on the final allowed sample, then a real timeout
    run_op("R9", 3'd3, 8'h00, 0, 3'd1, 0, 0, 0, 4 * DCLK + LIMIT, 8'h00, 0);
    run_op("R9", 3'd3, 8'h00, 0, 3'd1, 0, 0, 0, 1000000000, 8'h00, 0);
    idle("R9", 3);
    run_op("R9", 3'd0, 8'h30, 0, 3'd1, 0, 0, 0, 0, 8'h00, 0);
    idle("R9", 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule